// File: doc/BRIEF.md
# Programmable SCL Clock Generator

This block produces the serial clock for the master side of an I2C interface. It runs from a 4 MHz system clock. A 5-bit divider code and a rate-mode bit set the clock frequency. It drives an SCL level and a one-cycle strobe for each SCL edge. It also raises an error flag when the divider code is not allowed for the selected mode.

SCL pulses are grouped into frames. A frame holds eight data clocks. When the acknowledge option is on, a ninth clock is added, and an indicator marks that pulse. The generator runs only while it is enabled and a transfer is requested. When it is not running, SCL is left released, which means high.

Divider code N sets the rate:

- **Standard mode:** SCL runs at 500 kHz / N. The period is 8·N system cycles.
- **High-speed mode:** SCL runs at 1000 kHz / N. The period is 4·N cycles.
- **Exception:** high-speed code 5 gives 400 kHz with a 6-cycle low phase and a 4-cycle high phase.

The code and the mode are sampled at the start of each low phase.

Top module: `scl_clkgen`

## Requirements
- R1: In standard mode (`fast_mode`=0) with code N ≥ 5, the SCL low phase and the high phase each last 4·N system cycles.
- R2: In high-speed mode (`fast_mode`=1) with code N ≥ 3 and N ≠ 5, the low and high phases each last 2·N cycles.
- R3: In high-speed mode with code 5, the low phase lasts 6 cycles and the high phase lasts 4 cycles.
- R4: Some codes are not allowed: 0–4 in standard mode and 0–2 in high-speed mode. While idle with `enable` and `xfer_req` high, such a code sets `code_err` one cycle later. In that case `scl_out` stays 1 and no strobe fires. A legal code clears `code_err`.
- R5: `scl_fall` is 1 only in the first cycle of a low phase, and `scl_rise` is 1 only in the first cycle of a high phase. The two strobes are never 1 together.
- R6: A frame holds 8 falling edges when `ack_clk_en`=0 and 9 when it is 1. `ack_phase` is 1 from the ninth fall through the end of that pulse, and 0 otherwise. `frame_done` is a one-cycle pulse in the cycle after the last high phase of a frame.
- R7: A change to the code or the mode during a pulse leaves that pulse unchanged. The new setting applies from the next low phase.
- R8: When `enable` goes low, `scl_out` returns to 1 in the next cycle. When `xfer_req` goes low, the current pulse finishes its high phase, and then SCL stays high with no further strobes.
- R9: During reset, `scl_out` is 1, and `scl_rise`, `scl_fall`, `frame_done` and `code_err` are 0.
- R10: From idle, with `enable`, `xfer_req` and a legal code all present, `scl_fall` and a low `scl_out` appear one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 4 MHz system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Block enable; low releases SCL at once |
| xfer_req | input | 1 | Transfer request; keeps clocks running |
| fast_mode | input | 1 | 0 = standard rate, 1 = high-speed rate |
| div_code | input | 5 | Divider code N |
| ack_clk_en | input | 1 | Adds the ninth acknowledge clock to each frame |
| scl_out | output | 1 | SCL drive level (1 = released) |
| scl_rise | output | 1 | Strobe in the first cycle of a high phase |
| scl_fall | output | 1 | Strobe in the first cycle of a low phase |
| ack_phase | output | 1 | High during the acknowledge pulse |
| frame_done | output | 1 | One-cycle pulse after the last pulse of a frame |
| code_err | output | 1 | The requested code is not allowed |

## Verification
Every output comes from a register, so each result is due at the clock edge after its cause:

- A start request shows as a fall strobe one cycle later.
- An illegal code shows on `code_err` one cycle later.
- Dropping `enable` releases SCL one cycle later.

The bench drives inputs and samples outputs on the falling clock edge, so each check reads the settled value of the cycle it targets. Phase lengths are counted as the number of consecutive falling-edge samples at one SCL level. The counts are bounded by the edge strobes at both ends. A setting change is checked by counting both the current pulse and the pulse after it.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;

endpackage

// File: rtl/scl_rate_decode.sv
module scl_rate_decode #(
    parameter int CODE_W    = 5,
    parameter int HALF_W    = 7,
    parameter int STD_MUL   = 8,
    parameter int FAST_MUL  = 4,
    parameter int STD_MIN   = 5,
    parameter int FAST_MIN  = 3,
    parameter bit SPEC_EN   = 1'b1,
    parameter int SPEC_CODE = 5,
    parameter int SPEC_LOW  = 6,
    parameter int SPEC_HIGH = 4
) (
    input  logic              fast,
    input  logic [CODE_W-1:0] code,
    output logic [HALF_W-1:0] low_len,
    output logic [HALF_W-1:0] high_len,
    output logic              illegal
);
    localparam logic [HALF_W-1:0] STD_HALF  = HALF_W'(STD_MUL / 2);
    localparam logic [HALF_W-1:0] FAST_HALF = HALF_W'(FAST_MUL / 2);

    logic [HALF_W-1:0] code_ext;
    logic [HALF_W-1:0] half_len;
    logic              is_special;

    assign code_ext = HALF_W'(code);
    assign half_len = fast ? code_ext * FAST_HALF : code_ext * STD_HALF;
    assign illegal  = fast ? (code < CODE_W'(FAST_MIN)) : (code < CODE_W'(STD_MIN));

    generate
        if (SPEC_EN) begin : g_special
            assign is_special = fast && (code == CODE_W'(SPEC_CODE));
        end else begin : g_plain
            assign is_special = 1'b0;
        end
    endgenerate

    always_comb begin
        if (is_special) begin
            low_len  = HALF_W'(SPEC_LOW);
            high_len = HALF_W'(SPEC_HIGH);
        end else begin
            low_len  = half_len;
            high_len = half_len;
        end
    end
endmodule

// File: rtl/scl_pulse_counter.sv
module scl_pulse_counter #(
    parameter int DATA_BITS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    input  logic ack_en,
    output logic ack_phase,
    output logic frame_last
);
    localparam int CNT_W = $clog2(DATA_BITS + 1);
    localparam logic [CNT_W-1:0] ACK_IDX  = CNT_W'(DATA_BITS);
    localparam logic [CNT_W-1:0] LAST_DAT = CNT_W'(DATA_BITS - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign ack_phase  = (cnt_q == ACK_IDX);
    assign frame_last = ack_phase || ((cnt_q == LAST_DAT) && !ack_en);

    always_comb begin
        cnt_d = cnt_q;
        if (clear)
            cnt_d = '0;
        else if (step)
            cnt_d = frame_last ? '0 : cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= ACK_IDX);

    // R6
    ack_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_phase && step && !clear) |=> (cnt_q == '0));
endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen #(
    parameter int CODE_W    = 5,
    parameter int STD_MUL   = 8,
    parameter int FAST_MUL  = 4,
    parameter int STD_MIN   = 5,
    parameter int FAST_MIN  = 3,
    parameter bit SPEC_EN   = 1'b1,
    parameter int SPEC_CODE = 5,
    parameter int SPEC_LOW  = 6,
    parameter int SPEC_HIGH = 4,
    parameter int DATA_BITS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              xfer_req,
    input  logic              fast_mode,
    input  logic [CODE_W-1:0] div_code,
    input  logic              ack_clk_en,
    output logic              scl_out,
    output logic              scl_rise,
    output logic              scl_fall,
    output logic              ack_phase,
    output logic              frame_done,
    output logic              code_err
);
    import scl_gen_pkg::*;

    localparam int HALF_W = $clog2((STD_MUL / 2) * (2 ** CODE_W));

    typedef struct packed {
        phase_e            phase;
        logic [HALF_W-1:0] cnt;
        logic [HALF_W-1:0] high_len;
        logic              scl;
        logic              rise;
        logic              fall;
        logic              done;
        logic              err;
    } gen_state_t;

    gen_state_t cur_q, nxt_d;

    logic [HALF_W-1:0] dec_low, dec_high;
    logic              dec_illegal;
    logic              run;
    logic              step;
    logic              frame_last;

    scl_rate_decode #(
        .CODE_W(CODE_W), .HALF_W(HALF_W), .STD_MUL(STD_MUL), .FAST_MUL(FAST_MUL),
        .STD_MIN(STD_MIN), .FAST_MIN(FAST_MIN), .SPEC_EN(SPEC_EN),
        .SPEC_CODE(SPEC_CODE), .SPEC_LOW(SPEC_LOW), .SPEC_HIGH(SPEC_HIGH)
    ) u_decode (
        .fast    (fast_mode),
        .code    (div_code),
        .low_len (dec_low),
        .high_len(dec_high),
        .illegal (dec_illegal)
    );

    scl_pulse_counter #(.DATA_BITS(DATA_BITS)) u_pulses (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (cur_q.phase == PH_IDLE),
        .step      (step),
        .ack_en    (ack_clk_en),
        .ack_phase (ack_phase),
        .frame_last(frame_last)
    );

    assign run  = enable && xfer_req;
    assign step = (cur_q.phase == PH_HIGH) && (cur_q.cnt == '0);

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.rise = 1'b0;
        nxt_d.fall = 1'b0;
        nxt_d.done = 1'b0;
        if (!enable) begin
            nxt_d.phase = PH_IDLE;
            nxt_d.scl   = 1'b1;
            nxt_d.cnt   = '0;
            nxt_d.err   = 1'b0;
        end else begin
            case (cur_q.phase)
                PH_IDLE: begin
                    nxt_d.err = xfer_req && dec_illegal;
                    if (run && !dec_illegal) begin
                        nxt_d.phase    = PH_LOW;
                        nxt_d.scl      = 1'b0;
                        nxt_d.fall     = 1'b1;
                        nxt_d.cnt      = dec_low - HALF_W'(1);
                        nxt_d.high_len = dec_high;
                    end
                end
                PH_LOW: begin
                    if (cur_q.cnt == '0) begin
                        nxt_d.phase = PH_HIGH;
                        nxt_d.scl   = 1'b1;
                        nxt_d.rise  = 1'b1;
                        nxt_d.cnt   = cur_q.high_len - HALF_W'(1);
                    end else begin
                        nxt_d.cnt = cur_q.cnt - HALF_W'(1);
                    end
                end
                PH_HIGH: begin
                    if (cur_q.cnt == '0) begin
                        nxt_d.done = frame_last;
                        if (run && !dec_illegal) begin
                            nxt_d.phase    = PH_LOW;
                            nxt_d.scl      = 1'b0;
                            nxt_d.fall     = 1'b1;
                            nxt_d.cnt      = dec_low - HALF_W'(1);
                            nxt_d.high_len = dec_high;
                        end else begin
                            nxt_d.phase = PH_IDLE;
                            nxt_d.err   = run && dec_illegal;
                        end
                    end else begin
                        nxt_d.cnt = cur_q.cnt - HALF_W'(1);
                    end
                end
                default: begin
                    nxt_d.phase = PH_IDLE;
                    nxt_d.scl   = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q          <= '0;
            cur_q.phase    <= PH_IDLE;
            cur_q.scl      <= 1'b1;
            cur_q.high_len <= HALF_W'(1);
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign scl_out    = cur_q.scl;
    assign scl_rise   = cur_q.rise;
    assign scl_fall   = cur_q.fall;
    assign frame_done = cur_q.done;
    assign code_err   = cur_q.err;

    // R5
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({scl_rise, scl_fall}));

    // R5
    rise_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scl_rise |-> (scl_out && !$past(scl_out)));

    // R5
    fall_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scl_fall |-> (!scl_out && $past(scl_out)));

    // R4
    err_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code_err |-> (scl_out && !scl_fall));

    // R8
    disable_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (scl_out && !scl_fall && !code_err));

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);
endmodule

// File: tb/scl_clkgen_tb.sv
module scl_clkgen_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0, xfer_req = 1'b0, fast_mode = 1'b0, ack_clk_en = 1'b0;
    logic [4:0] div_code = 5'd5;
    logic       scl_out, scl_rise, scl_fall, ack_phase, frame_done, code_err;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    scl_clkgen u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .xfer_req(xfer_req),
        .fast_mode(fast_mode), .div_code(div_code), .ack_clk_en(ack_clk_en),
        .scl_out(scl_out), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .ack_phase(ack_phase), .frame_done(frame_done), .code_err(code_err)
    );

    // {fast, code, err, low, high}
    localparam int NV = 12;
    localparam logic [22:0] VEC [NV] = '{
        {1'b0, 5'd5,  1'b0, 8'd20,  8'd20},   // R1
        {1'b0, 5'd6,  1'b0, 8'd24,  8'd24},   // R1
        {1'b0, 5'd31, 1'b0, 8'd124, 8'd124},  // R1
        {1'b0, 5'd4,  1'b1, 8'd0,   8'd0},    // R4
        {1'b0, 5'd0,  1'b1, 8'd0,   8'd0},    // R4
        {1'b1, 5'd3,  1'b0, 8'd6,   8'd6},    // R2
        {1'b1, 5'd4,  1'b0, 8'd8,   8'd8},    // R2
        {1'b1, 5'd5,  1'b0, 8'd6,   8'd4},    // R3
        {1'b1, 5'd6,  1'b0, 8'd12,  8'd12},   // R2
        {1'b1, 5'd31, 1'b0, 8'd62,  8'd62},   // R2
        {1'b1, 5'd2,  1'b1, 8'd0,   8'd0},    // R4
        {1'b1, 5'd0,  1'b1, 8'd0,   8'd0}     // R4
    };

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // starts at a negedge showing scl_fall, ends at the next one
    task automatic meas(output int lo, output int hi);
        lo = 0;
        while (scl_out == 1'b0) begin lo++; @(negedge clk); end
        chk(scl_rise == 1'b1, "R5 rise strobe", scl_rise, 1);
        hi = 0;
        while (scl_out == 1'b1) begin hi++; @(negedge clk); end
        chk(scl_fall == 1'b1, "R5 fall strobe", scl_fall, 1);
    endtask

    task automatic stop_all();
        enable = 1'b0; xfer_req = 1'b0;
        @(negedge clk);
        chk(scl_out == 1'b1, "R8 enable low releases", scl_out, 1);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int lo, hi, n;
        logic ack_seen;
        repeat (3) @(negedge clk);
        chk(scl_out == 1'b1, "R9 scl in reset", scl_out, 1);
        chk({scl_rise, scl_fall, frame_done, code_err} == 4'b0, "R9 flags in reset",
            {scl_rise, scl_fall, frame_done, code_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            fast_mode = VEC[i][22]; div_code = VEC[i][21:17];
            enable = 1'b1; xfer_req = 1'b1;
            @(negedge clk);
            if (VEC[i][16]) begin
                for (int k = 0; k < 4; k++) begin
                    chk(code_err && scl_out && !scl_fall && !scl_rise, "R4 illegal code",
                        {code_err, scl_out, scl_fall}, 3'b110);
                    @(negedge clk);
                end
            end else begin
                chk(scl_fall && !scl_out, "R10 start", scl_fall, 1);
                chk(!code_err, "R4 legal no err", code_err, 0);
                meas(lo, hi);
                chk(lo == int'(VEC[i][15:8]), "R1/R2/R3 low length", lo, VEC[i][15:8]);
                chk(hi == int'(VEC[i][7:0]), "R1/R2/R3 high length", hi, VEC[i][7:0]);
            end
            stop_all();
        end

        // R4: error clears on legal code
        fast_mode = 1'b0; div_code = 5'd3; enable = 1'b1; xfer_req = 1'b1;
        @(negedge clk);
        chk(code_err, "R4 err set", code_err, 1);
        div_code = 5'd5;
        @(negedge clk);
        chk(!code_err && scl_fall, "R4 err cleared by legal code", code_err, 0);
        stop_all();

        // R7: change during pulse applies next low
        div_code = 5'd5; enable = 1'b1; xfer_req = 1'b1;
        @(negedge clk);
        div_code = 5'd6;
        meas(lo, hi);
        chk(lo == 20 && hi == 20, "R7 current pulse kept", lo + hi, 40);
        meas(lo, hi);
        chk(lo == 24 && hi == 24, "R7 new code next pulse", lo + hi, 48);
        stop_all();

        // R4 R7: illegal code picked at end of high phase
        div_code = 5'd5; enable = 1'b1; xfer_req = 1'b1;
        @(negedge clk);
        div_code = 5'd4;
        while (!scl_rise) @(negedge clk);
        repeat (20) @(negedge clk);
        chk(code_err && scl_out, "R4 illegal at pulse end", code_err, 1);
        stop_all();

        // R8: request drop finishes pulse
        div_code = 5'd5; enable = 1'b1; xfer_req = 1'b1;
        @(negedge clk);
        xfer_req = 1'b0;
        n = 0;
        while (!scl_rise) begin n++; @(negedge clk); end
        chk(n == 20, "R8 low phase completes", n, 20);
        n = 0;
        for (int k = 0; k < 60; k++) begin
            if (scl_out && !scl_fall) n++;
            @(negedge clk);
        end
        chk(n == 60, "R8 stays high after request drop", n, 60);
        stop_all();

        // R8: enable drop mid low
        enable = 1'b1; xfer_req = 1'b1;
        repeat (6) @(negedge clk);
        chk(!scl_out, "R8 low before disable", scl_out, 0);
        enable = 1'b0;
        @(negedge clk);
        chk(scl_out && !code_err, "R8 disable mid low", scl_out, 1);
        stop_all();

        // R6: frames of 8 then 9 pulses
        ack_clk_en = 1'b0; enable = 1'b1; xfer_req = 1'b1;
        @(negedge clk);
        n = 0; ack_seen = 1'b0;
        do begin
            if (scl_fall) n++;
            if (ack_phase) ack_seen = 1'b1;
            @(negedge clk);
        end while (!frame_done);
        chk(n == 8, "R6 frame without ack", n, 8);
        chk(!ack_seen, "R6 no ack phase", ack_seen, 0);
        ack_clk_en = 1'b1;
        n = 0;
        do begin
            if (scl_fall) begin
                n++;
                if (n == 8) chk(!ack_phase, "R6 ack low on 8th", ack_phase, 0);
                if (n == 9) chk(ack_phase, "R6 ack high on 9th", ack_phase, 1);
            end
            @(negedge clk);
            if (!frame_done && n == 9)
                chk(ack_phase, "R6 ack held through pulse", ack_phase, 1);
        end while (!frame_done);
        chk(n == 9, "R6 frame with ack", n, 9);
        chk(!ack_phase, "R6 ack cleared at frame end", ack_phase, 0);
        @(negedge clk);
        chk(!frame_done, "R6 frame_done one cycle", frame_done, 0);
        stop_all();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule